// File: doc/BRIEF.md
# Power domain switch sequencer

This block steps one power-gated logic domain between a fully powered state and a fully collapsed state. Software programs a control word through a small register port. The word selects the target state, either through a collapse bit or through an external request pin. It also holds an override bit that blocks new transitions and three run-time wait exponents. Each wait exponent n gives a delay of 2^n cycles of `clk`, which serves as the reference clock.

A power-down gates the domain clock, waits, opens every power switch and then clamps the domain's outputs. A power-up pulses an always-on reset under the clamp, releases the clamp, closes a small group of switches, waits, closes the rest, waits again and finally ungates the clock. Each sequence starts after a fixed startup latency. A separate config word carries the up-complete and down-complete flags and two retention controls that are passed straight to the domain.

The states are `ST_ON`, `ST_DN_START`, `ST_DN_CLKOFF`, `ST_DN_OPEN`, `ST_OFF`, `ST_UP_START`, `ST_UP_RST`, `ST_UP_FEW` and `ST_UP_REST`. The transitions are:
- ON to DN_START when a power-down is wanted and override is clear.
- DN_START to DN_CLKOFF after the startup latency.
- DN_CLKOFF to DN_OPEN after the clock-disable wait.
- DN_OPEN to OFF after one cycle.
- OFF to UP_START when a power-up is wanted and override is clear.
- UP_START to UP_RST after the startup latency.
- UP_RST to UP_FEW after one cycle.
- UP_FEW to UP_REST after the few-switch wait.
- UP_REST to ON after the rest-switch wait.

Top module: `pd_switch_seq`

## Requirements
- R1: After reset the domain is on. The control word (byte address 0) reads 0x8000_0000, the config word (byte address 4) reads 0x0001_0000, `iso_clamp` is 0 and `dom_clk_en` is 1.
- R2: In the control word, bit 0 (collapse), bit 1 (hardware trigger), bit 2 (override), bits 23:20 (rest wait), 19:16 (few wait) and 15:12 (clock wait) are writable and read back. Every other bit reads 0, except bit 31. In the config word, bits 14 and 13 are writable and drive `ret_mem` and `ret_periph`. Bits 16 and 15 of the config word are read-only. Any other address reads 0.
- R3: Power-down order is: `dom_clk_en` falls, 2^clock-wait cycles later both switch enables fall, and one cycle after that `iso_clamp` rises. While `iso_clamp` is 1 both switches are open, and the clock is never enabled with a switch open.
- R4: Power-up order is: `aon_rst` is high for exactly one cycle while the clamp is still set. The next cycle the clamp falls and `sw_few_en` rises. 2^few-wait cycles later `sw_rest_en` rises, and 2^rest-wait cycles after that `dom_clk_en` rises.
- R5: The first output change of either sequence comes START_LAT (default 8) cycles after the cycle in which the request is first seen in a stable state.
- R6: Status bit 31 reads 1 only once the domain is fully on and 0 once it is fully off, and holds its last value during a sequence. Config bit 16 (up complete) is 1 only in the fully-on state and bit 15 (down complete) only in the fully-off state. The two are never both set.
- R7: With control bit 1 set, `hw_req` (1 = power on, 0 = collapse) selects the target and control bit 0 has no effect.
- R8: With control bit 2 set, no new sequence starts from a stable state.
- R9: A request change during a sequence does not abort it. It is acted on once the sequence reaches a stable state.
- R10: A wait field value n gives a phase of 2^n cycles, and n = 0 gives a single cycle. The rest switches are never enabled without the few switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address (0 control, 4 config) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| hw_req | input | 1 | Hardware power request, 1 = on |
| dom_clk_en | output | 1 | Domain clock enable |
| sw_few_en | output | 1 | Enable for the first few power switches |
| sw_rest_en | output | 1 | Enable for the remaining power switches |
| iso_clamp | output | 1 | Output clamp of the domain |
| aon_rst | output | 1 | Always-on reset pulse before clamp release |
| ret_mem | output | 1 | Memory retention control |
| ret_periph | output | 1 | Peripheral retention control |

## Verification
A register write becomes visible on `reg_rdata` from the clock edge that samples the strobe. The sequencer first reacts one edge later, and the first output change of a sequence follows START_LAT cycles after that. Each later phase boundary falls exactly 2^n cycles further on. The bench model schedules one expected output vector per future clock edge at the moment it accepts a request, and compares all outputs and the read data 1 ns after every rising edge, when every register on the path has settled. The directed checks count negative edges from the write strobe, so that the cycle just before and the cycle just after the startup latency are both sampled.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int WAIT_W = 4;
    localparam int REG_W  = 32;

    // control word bit positions
    localparam int CTL_COLLAPSE = 0;
    localparam int CTL_HWTRIG   = 1;
    localparam int CTL_OVR      = 2;
    localparam int CTL_WCLK_LSB = 12;
    localparam int CTL_WFEW_LSB = 16;
    localparam int CTL_WRST_LSB = 20;
    localparam int CTL_STATUS   = 31;

    // config word bit positions
    localparam int CFG_RPER = 13;
    localparam int CFG_RMEM = 14;
    localparam int CFG_DN   = 15;
    localparam int CFG_UP   = 16;

    typedef enum logic [3:0] {
        ST_ON,
        ST_DN_START,
        ST_DN_CLKOFF,
        ST_DN_OPEN,
        ST_OFF,
        ST_UP_START,
        ST_UP_RST,
        ST_UP_FEW,
        ST_UP_REST
    } pds_state_e;

    typedef struct packed {
        logic              collapse;
        logic              hw_trig;
        logic              ovr;
        logic [WAIT_W-1:0] w_rest;
        logic [WAIT_W-1:0] w_few;
        logic [WAIT_W-1:0] w_clk;
    } pds_ctrl_t;

endpackage

// File: rtl/pds_regs.sv
module pds_regs
    import pds_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int CTL_ADDR = 0,
    parameter int CFG_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              pwr_on,
    input  logic              up_done,
    input  logic              dn_done,
    output pds_ctrl_t         ctrl,
    output logic              ret_mem,
    output logic              ret_per,
    output logic [REG_W-1:0]  rdata
);

    logic sel_ctl;
    logic sel_cfg;
    logic unused_wbits;

    assign sel_ctl = (addr == ADDR_W'(CTL_ADDR));
    assign sel_cfg = (addr == ADDR_W'(CFG_ADDR));
    assign unused_wbits = ^{wdata[31:24], wdata[11:3], wdata[12+:1] & 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            ret_mem <= 1'b0;
            ret_per <= 1'b0;
        end else if (we) begin
            if (sel_ctl) begin
                ctrl.collapse <= wdata[CTL_COLLAPSE];
                ctrl.hw_trig  <= wdata[CTL_HWTRIG];
                ctrl.ovr      <= wdata[CTL_OVR];
                ctrl.w_rest   <= wdata[CTL_WRST_LSB +: WAIT_W];
                ctrl.w_few    <= wdata[CTL_WFEW_LSB +: WAIT_W];
                ctrl.w_clk    <= wdata[CTL_WCLK_LSB +: WAIT_W];
            end
            if (sel_cfg) begin
                ret_mem <= wdata[CFG_RMEM];
                ret_per <= wdata[CFG_RPER];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_ctl) begin
            rdata[CTL_COLLAPSE]              = ctrl.collapse;
            rdata[CTL_HWTRIG]                = ctrl.hw_trig;
            rdata[CTL_OVR]                   = ctrl.ovr;
            rdata[CTL_WRST_LSB +: WAIT_W]    = ctrl.w_rest;
            rdata[CTL_WFEW_LSB +: WAIT_W]    = ctrl.w_few;
            rdata[CTL_WCLK_LSB +: WAIT_W]    = ctrl.w_clk;
            rdata[CTL_STATUS]                = pwr_on;
        end else if (sel_cfg) begin
            rdata[CFG_UP]   = up_done;
            rdata[CFG_DN]   = dn_done;
            rdata[CFG_RMEM] = ret_mem;
            rdata[CFG_RPER] = ret_per;
        end
    end

endmodule

// File: rtl/pds_timer.sv
module pds_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
#(
    parameter int START_LAT = 8,
    parameter int CNT_W     = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pds_ctrl_t        ctrl,
    input  logic             hw_req,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             dom_clk_en,
    output logic             sw_few_en,
    output logic             sw_rest_en,
    output logic             iso_clamp,
    output logic             aon_rst,
    output logic             up_done,
    output logic             dn_done,
    output logic             pwr_on
);

    localparam logic [CNT_W-1:0] LAT_M1 = CNT_W'(START_LAT - 1);

    pds_state_e state_q;
    pds_state_e state_d;
    logic       want_off;

    // a wait of 2^n cycles loads n ones into the down counter
    function automatic logic [CNT_W-1:0] wait_m1(input logic [WAIT_W-1:0] n);
        logic [CNT_W-1:0] m;
        for (int i = 0; i < CNT_W; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction

    assign want_off = ctrl.hw_trig ? !hw_req : ctrl.collapse;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_ON: begin
                if (!ctrl.ovr && want_off) begin
                    state_d  = ST_DN_START;
                    tmr_load = 1'b1;
                    tmr_val  = LAT_M1;
                end
            end
            ST_DN_START: begin
                if (tmr_done) begin
                    state_d  = ST_DN_CLKOFF;
                    tmr_load = 1'b1;
                    tmr_val  = wait_m1(ctrl.w_clk);
                end
            end
            ST_DN_CLKOFF: begin
                if (tmr_done) begin
                    state_d = ST_DN_OPEN;
                end
            end
            ST_DN_OPEN: begin
                state_d = ST_OFF;
            end
            ST_OFF: begin
                if (!ctrl.ovr && !want_off) begin
                    state_d  = ST_UP_START;
                    tmr_load = 1'b1;
                    tmr_val  = LAT_M1;
                end
            end
            ST_UP_START: begin
                if (tmr_done) begin
                    state_d = ST_UP_RST;
                end
            end
            ST_UP_RST: begin
                state_d  = ST_UP_FEW;
                tmr_load = 1'b1;
                tmr_val  = wait_m1(ctrl.w_few);
            end
            ST_UP_FEW: begin
                if (tmr_done) begin
                    state_d  = ST_UP_REST;
                    tmr_load = 1'b1;
                    tmr_val  = wait_m1(ctrl.w_rest);
                end
            end
            ST_UP_REST: begin
                if (tmr_done) begin
                    state_d = ST_ON;
                end
            end
            default: state_d = ST_ON;
        endcase
    end

    // state register and status bit that only moves in stable states
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ON;
            pwr_on  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_d == ST_ON) begin
                pwr_on <= 1'b1;
            end else if (state_d == ST_OFF) begin
                pwr_on <= 1'b0;
            end
        end
    end

    always_comb begin
        dom_clk_en = 1'b0;
        sw_few_en  = 1'b0;
        sw_rest_en = 1'b0;
        iso_clamp  = 1'b0;
        aon_rst    = 1'b0;
        up_done    = 1'b0;
        dn_done    = 1'b0;
        unique case (state_q)
            ST_ON: begin
                dom_clk_en = 1'b1;
                sw_few_en  = 1'b1;
                sw_rest_en = 1'b1;
                up_done    = 1'b1;
            end
            ST_DN_START: begin
                dom_clk_en = 1'b1;
                sw_few_en  = 1'b1;
                sw_rest_en = 1'b1;
            end
            ST_DN_CLKOFF: begin
                sw_few_en  = 1'b1;
                sw_rest_en = 1'b1;
            end
            ST_DN_OPEN: begin
            end
            ST_OFF: begin
                iso_clamp = 1'b1;
                dn_done   = 1'b1;
            end
            ST_UP_START: begin
                iso_clamp = 1'b1;
            end
            ST_UP_RST: begin
                iso_clamp = 1'b1;
                aon_rst   = 1'b1;
            end
            ST_UP_FEW: begin
                sw_few_en = 1'b1;
            end
            ST_UP_REST: begin
                sw_few_en  = 1'b1;
                sw_rest_en = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/pd_switch_seq.sv
module pd_switch_seq
    import pds_pkg::*;
#(
    parameter int START_LAT = 8,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              hw_req,
    output logic              dom_clk_en,
    output logic              sw_few_en,
    output logic              sw_rest_en,
    output logic              iso_clamp,
    output logic              aon_rst,
    output logic              ret_mem,
    output logic              ret_periph
);

    localparam int WAIT_BITS = (1 << WAIT_W) - 1;
    localparam int LAT_BITS  = $clog2(START_LAT + 1);
    localparam int CNT_W     = (WAIT_BITS > LAT_BITS) ? WAIT_BITS : LAT_BITS;

    pds_ctrl_t        ctrl;
    logic             up_done;
    logic             dn_done;
    logic             pwr_on;
    logic             tmr_load;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_val;

    pds_regs #(
        .ADDR_W   (ADDR_W),
        .CTL_ADDR (0),
        .CFG_ADDR (4)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .pwr_on  (pwr_on),
        .up_done (up_done),
        .dn_done (dn_done),
        .ctrl    (ctrl),
        .ret_mem (ret_mem),
        .ret_per (ret_periph),
        .rdata   (reg_rdata)
    );

    pds_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pds_fsm #(
        .START_LAT (START_LAT),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl),
        .hw_req     (hw_req),
        .tmr_done   (tmr_done),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .dom_clk_en (dom_clk_en),
        .sw_few_en  (sw_few_en),
        .sw_rest_en (sw_rest_en),
        .iso_clamp  (iso_clamp),
        .aon_rst    (aon_rst),
        .up_done    (up_done),
        .dn_done    (dn_done),
        .pwr_on     (pwr_on)
    );

endmodule

// File: rtl/pds_checker.sv
module pds_checker (
    input logic clk,
    input logic rst_n,
    input logic dom_clk_en,
    input logic sw_few_en,
    input logic sw_rest_en,
    input logic iso_clamp,
    input logic aon_rst,
    input logic up_done,
    input logic dn_done,
    input logic pwr_on
);

    AST_CLAMP_SW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        iso_clamp |-> (!sw_few_en && !sw_rest_en)); // R3

    AST_CLK_SW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        dom_clk_en |-> (sw_few_en && sw_rest_en)); // R3

    AST_REST_NEEDS_FEW: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rest_en |-> sw_few_en); // R10

    AST_RST_UNDER_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        aon_rst |-> iso_clamp); // R4

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        aon_rst |=> !aon_rst); // R4

    AST_CLAMP_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_clamp) |-> $past(aon_rst)); // R4

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_done && dn_done)); // R6

    AST_UP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        up_done |-> pwr_on); // R6

    AST_DN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        dn_done |-> !pwr_on); // R6

endmodule

bind pd_switch_seq pds_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dom_clk_en (dom_clk_en),
    .sw_few_en  (sw_few_en),
    .sw_rest_en (sw_rest_en),
    .iso_clamp  (iso_clamp),
    .aon_rst    (aon_rst),
    .up_done    (up_done),
    .dn_done    (dn_done),
    .pwr_on     (pwr_on)
);

// File: tb/sim_pd_switch_seq.sv
`timescale 1ns/1ps
module sim_pd_switch_seq;

    localparam int LAT = 8;
    localparam logic [31:0] CTL_MASK = 32'h00FF_F007;
    localparam logic [31:0] CFG_MASK = 32'h0000_6000;
    // vector bits: 7 clk, 6 few, 5 rest, 4 clamp, 3 rst, 2 status, 1 up, 0 down
    localparam logic [7:0] V_ON   = 8'hE6;
    localparam logic [7:0] V_OFF  = 8'h11;
    localparam logic [7:0] V_DST  = 8'hE4;
    localparam logic [7:0] V_DCLK = 8'h64;
    localparam logic [7:0] V_DOPN = 8'h04;
    localparam logic [7:0] V_UST  = 8'h10;
    localparam logic [7:0] V_URST = 8'h18;
    localparam logic [7:0] V_UFEW = 8'h40;
    localparam logic [7:0] V_UREST = 8'h60;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        hw_req;
    logic        dom_clk_en, sw_few_en, sw_rest_en, iso_clamp, aon_rst, ret_mem, ret_periph;

    int n_chk = 0;
    int n_err = 0;
    logic seen_clamp = 1'b0;

    always #2.5 clk = ~clk;

    pd_switch_seq #(.START_LAT(LAT), .ADDR_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
        .dom_clk_en(dom_clk_en), .sw_few_en(sw_few_en), .sw_rest_en(sw_rest_en),
        .iso_clamp(iso_clamp), .aon_rst(aon_rst), .ret_mem(ret_mem), .ret_periph(ret_periph)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model: one expected vector per future edge
    logic [7:0]  q[$];
    logic [31:0] m_ctl;
    logic [31:0] m_cfg;
    logic        m_on;
    logic [7:0]  ev;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_ctl = '0;
            m_cfg = '0;
            m_on  = 1'b1;
        end else begin
            if (q.size() == 0) begin
                logic want_off;
                want_off = m_ctl[1] ? !hw_req : m_ctl[0];
                if (!m_ctl[2] && (want_off == m_on)) begin
                    if (m_on) begin
                        for (int i = 0; i < LAT; i++) q.push_back(V_DST);
                        for (int i = 0; i < (1 << m_ctl[15:12]); i++) q.push_back(V_DCLK);
                        q.push_back(V_DOPN);
                        q.push_back(V_OFF);
                    end else begin
                        for (int i = 0; i < LAT; i++) q.push_back(V_UST);
                        q.push_back(V_URST);
                        for (int i = 0; i < (1 << m_ctl[19:16]); i++) q.push_back(V_UFEW);
                        for (int i = 0; i < (1 << m_ctl[23:20]); i++) q.push_back(V_UREST);
                        q.push_back(V_ON);
                    end
                    m_on = !m_on;
                end
            end
            if (q.size() != 0) ev = q.pop_front();
            else ev = m_on ? V_ON : V_OFF;
            if (reg_we && reg_addr == 3'd0) m_ctl = reg_wdata & CTL_MASK;
            if (reg_we && reg_addr == 3'd4) m_cfg = reg_wdata & CFG_MASK;
            #1;
            if (iso_clamp) seen_clamp = 1'b1;
            chk("R3 clk_en", {31'b0, dom_clk_en}, {31'b0, ev[7]});
            chk("R4 sw_few", {31'b0, sw_few_en}, {31'b0, ev[6]});
            chk("R10 sw_rest", {31'b0, sw_rest_en}, {31'b0, ev[5]});
            chk("R3 clamp", {31'b0, iso_clamp}, {31'b0, ev[4]});
            chk("R4 aon_rst", {31'b0, aon_rst}, {31'b0, ev[3]});
            chk("R2 ret", {30'b0, ret_mem, ret_periph}, {30'b0, m_cfg[14], m_cfg[13]});
            if (reg_addr == 3'd0)
                chk("R6 ctl read", reg_rdata, m_ctl | {ev[2], 31'b0});
            else if (reg_addr == 3'd4)
                chk("R6 cfg read", reg_rdata, m_cfg | {15'b0, ev[1], ev[0], 15'b0});
            else
                chk("R2 unmapped read", reg_rdata, 32'h0);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; hw_req = 1'b1;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, d); chk("R1 ctl after reset", d, 32'h8000_0000);
        rd(3'd4, d); chk("R1 cfg after reset", d, 32'h0001_0000);
        chk("R1 clamp", {31'b0, iso_clamp}, 32'h0);
        chk("R1 clk_en", {31'b0, dom_clk_en}, 32'h1);

        // R2 layout and read-only bits
        wr(3'd0, 32'hFF21_2FF8);
        rd(3'd0, d); chk("R2 ctl readback", d, 32'h8021_2000);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d); chk("R2 cfg readback", d, 32'h0001_6000);
        chk("R2 retention outs", {30'b0, ret_mem, ret_periph}, 32'h3);
        rd(3'd2, d); chk("R2 unmapped", d, 32'h0);
        wr(3'd4, 32'h0000_2000);
        chk("R2 ret_mem cleared", {30'b0, ret_mem, ret_periph}, 32'h1);

        // R5 latency, R3 power-down
        reg_addr = 3'd0;
        wr(3'd0, 32'h0021_2001);
        idle(LAT);
        chk("R5 clk_en before latency", {31'b0, dom_clk_en}, 32'h1);
        chk("R6 status held", {31'b0, reg_rdata[31]}, 32'h1);
        idle(1);
        chk("R5 clk_en after latency", {31'b0, dom_clk_en}, 32'h0);
        idle(30);
        rd(3'd0, d); chk("R3 status off", d, 32'h0021_2001);
        rd(3'd4, d); chk("R3 down flag", d, 32'h0000_A000);
        chk("R3 clamp set", {31'b0, iso_clamp}, 32'h1);

        // R4 power-up
        wr(3'd0, 32'h0021_2000);
        idle(40);
        rd(3'd0, d); chk("R4 status on", d, 32'h8021_2000);
        chk("R4 clk_en on", {31'b0, dom_clk_en}, 32'h1);

        // R9 request changes in flight
        seen_clamp = 1'b0;
        wr(3'd0, 32'h0021_2001);
        idle(3);
        wr(3'd0, 32'h0021_2000);
        idle(60);
        chk("R9 sequence completed", {31'b0, seen_clamp}, 32'h1);
        rd(3'd0, d); chk("R9 back on", d, 32'h8021_2000);

        // R8 override
        wr(3'd0, 32'h0021_2005);
        idle(30);
        rd(3'd0, d); chk("R8 held on", d, 32'h8021_2005);
        wr(3'd0, 32'h0021_2001);
        idle(30);
        rd(3'd0, d); chk("R8 released", d, 32'h0021_2001);

        // R7 hardware trigger
        @(negedge clk); hw_req = 1'b0;
        wr(3'd0, 32'h0021_2002);
        idle(30);
        rd(3'd0, d); chk("R7 bit0 ignored", d, 32'h0021_2002);
        @(negedge clk); hw_req = 1'b1;
        idle(40);
        rd(3'd0, d); chk("R7 hw on", d, 32'h8021_2002);
        wr(3'd0, 32'h0021_2003);
        idle(30);
        rd(3'd0, d); chk("R7 bit0 ignored on", d, 32'h8021_2003);
        @(negedge clk); hw_req = 1'b0;
        idle(30);
        rd(3'd0, d); chk("R7 hw off", d, 32'h0021_2003);

        // R10 longer waits
        wr(3'd0, 32'h0004_4000);
        idle(60);
        rd(3'd0, d); chk("R10 up with 16-cycle wait", d, 32'h8004_4000);
        wr(3'd0, 32'h0004_4001);
        idle(60);
        rd(3'd0, d); chk("R10 down with 16-cycle wait", d, 32'h0004_4001);

        summary();
        $finish;
    end

endmodule